// File: doc/BRIEF.md
# Packet Buffer Reservation Admission Controller

This block keeps the count of free pages in a packet buffer that transmit and receive traffic share. It decides in the same cycle whether each transmit or receive allocation request is granted. Pages come back through two release ports, one per direction. A soft reset command from the allocator returns every page to the free pool.

A host configuration word sets a transmit reservation in its low byte. Receive requests are refused while free memory is at or below that reservation. Transmit requests never look at it. The high byte is read-only and carries a three-bit identity code that fixes the page multiplier M, so one page is 256 × M bytes. The reservation and the free count are both measured in these pages. The reservation lives outside the allocator's own reset, so a soft reset leaves it unchanged.

Top module: `pbuf_admit`

## Requirements
- R1: After hardware reset, free_pages is 256, the reservation reads 0 and both grants are low while no request is presented.
- R2: cfg_rd_data holds the reservation in bits 7..0 and the identity code in bits 11..9. Bits 15..12 and bit 8 read 0. With the default code 3'b010 the word after reset is 16'h0400.
- R3: A write with cfg_wr_be[0] high loads cfg_wr_data[7..0] into the reservation. Data in bits 15..8 and the byte enable cfg_wr_be[1] change nothing in the word.
- R4: tx_grant is high in the same cycle when tx_req is high and tx_pages is at most the available pages. On the next clock edge, free_pages falls by the pages granted.
- R5: With the reservation at 0, rx_grant follows only whether rx_pages fits in the pages left after any transmit grant.
- R6: With a non-zero reservation, rx_grant is low whenever the pages left after any transmit grant are less than or equal to the reservation.
- R7: A transmit request is judged without regard to the reservation.
- R8: Releases from both ports are added before allocations in the same cycle. The sum saturates at 256.
- R9: When both directions request in one cycle, the transmit request is judged first. The receive request then sees only what remains.
- R10: While soft_rst is high, both grants are low and free_pages becomes 256 at the next edge. The reservation keeps its value.
- R11: page_mult reports M from the identity code: 001→1, 010→2, 011→4, 100→8, 101→16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_be | input | 2 | Byte enables for the write |
| cfg_wr_data | input | 16 | Configuration write data |
| cfg_rd_data | output | 16 | Configuration word read value |
| page_mult | output | 5 | Page multiplier M |
| soft_rst | input | 1 | Allocator soft reset command |
| tx_req | input | 1 | Transmit allocation request |
| tx_pages | input | 8 | Transmit pages requested |
| tx_grant | output | 1 | Transmit request granted |
| rx_req | input | 1 | Receive allocation request |
| rx_pages | input | 8 | Receive pages requested |
| rx_grant | output | 1 | Receive request granted |
| tx_rel | input | 1 | Transmit release strobe |
| tx_rel_pages | input | 8 | Transmit pages released |
| rx_rel | input | 1 | Receive release strobe |
| rx_rel_pages | input | 8 | Receive pages released |
| free_pages | output | 9 | Free pages in units of 256 × M bytes |

## Verification
The grants are combinational, so the bench samples them one time unit after it drives the request, in the same cycle. The free count and the reservation are registered, so the bench checks them one time unit after the next rising edge. A behavioural integer model steps at that same edge. The model and the design are compared on every cycle of long random traffic and of directed corner cases: exact fit, reservation equality, simultaneous requests, saturating releases and soft reset.

// File: rtl/pbuf_admit_pkg.sv
// Package: shared constants and the identity-to-multiplier decode.
// Assumes a 16-bit configuration word with the identity code at bits 11..9.
package pbuf_admit_pkg;
    localparam int CFG_W  = 16;
    localparam int RESV_W = 8;
    localparam int ID_W   = 3;
    localparam int MULT_W = 5;

    // Decode the identity code to the page multiplier; unknown codes give 0.
    function automatic logic [MULT_W-1:0] id_to_mult(input logic [ID_W-1:0] code);
        logic [MULT_W-1:0] m;
        if (code >= 3'd1 && code <= 3'd5) m = MULT_W'(1) << (code - 3'd1);
        else m = '0;
        return m;
    endfunction
endpackage

// File: rtl/pbuf_cfg_regs.sv
// Configuration word: writable reservation byte plus a fixed identity field.
// Assumes only hardware reset clears the reservation; soft reset is not seen here.
module pbuf_cfg_regs
    import pbuf_admit_pkg::*;
#(
    parameter logic [ID_W-1:0] ID_CODE = 3'b010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_be,
    input  logic [CFG_W-1:0]  wr_data,
    output logic [CFG_W-1:0]  rd_data,
    output logic [RESV_W-1:0] resv,
    output logic [MULT_W-1:0] mult
);
    logic unused_hi;
    assign unused_hi = ^{wr_be[1], wr_data[CFG_W-1:RESV_W]};

    // Hold the reservation byte; only the low byte lane can load it.
    always_ff @(posedge clk) begin
        if (!rst_n) resv <= '0;
        else if (wr_en && wr_be[0]) resv <= wr_data[RESV_W-1:0];
    end

    // Assemble the read word with the fixed identity field.
    always_comb begin
        rd_data = '0;
        rd_data[RESV_W-1:0] = resv;
        rd_data[11:9] = ID_CODE;
    end

    assign mult = id_to_mult(ID_CODE);
endmodule

// File: rtl/pbuf_admit_logic.sv
// Combinational admission: releases first, then transmit, then receive.
// Assumes request widths are narrower than the free counter.
module pbuf_admit_logic
    import pbuf_admit_pkg::*;
#(
    parameter int REQ_W  = 8,
    parameter int TOTAL  = 256,
    parameter int FREE_W = 9
) (
    input  logic [FREE_W-1:0] free_q,
    input  logic [RESV_W-1:0] resv,
    input  logic              soft_rst,
    input  logic              tx_req,
    input  logic [REQ_W-1:0]  tx_pages,
    input  logic              rx_req,
    input  logic [REQ_W-1:0]  rx_pages,
    input  logic              tx_rel,
    input  logic [REQ_W-1:0]  tx_rel_pages,
    input  logic              rx_rel,
    input  logic [REQ_W-1:0]  rx_rel_pages,
    output logic              tx_grant,
    output logic              rx_grant,
    output logic [FREE_W-1:0] free_d
);
    localparam int SUM_W = FREE_W + 2;
    localparam logic [SUM_W-1:0] TOTAL_S = SUM_W'(TOTAL);

    logic [SUM_W-1:0] sum, avail, after_tx, after_rx, txp, rxp;
    logic             resv_ok;

    // Apply releases with saturation, then grant transmit and receive in order.
    always_comb begin
        txp   = SUM_W'(tx_pages);
        rxp   = SUM_W'(rx_pages);
        sum   = SUM_W'(free_q)
              + (tx_rel ? SUM_W'(tx_rel_pages) : '0)
              + (rx_rel ? SUM_W'(rx_rel_pages) : '0);
        avail = (sum > TOTAL_S) ? TOTAL_S : sum;
        tx_grant = !soft_rst && tx_req && (txp <= avail);
        after_tx = avail - (tx_grant ? txp : '0);
        resv_ok  = (resv == '0) || (after_tx > SUM_W'(resv));
        rx_grant = !soft_rst && rx_req && (rxp <= after_tx) && resv_ok;
        after_rx = after_tx - (rx_grant ? rxp : '0);
        free_d   = after_rx[FREE_W-1:0];
    end
endmodule

// File: rtl/pbuf_free_ctr.sv
// Free-page register: full on hardware or soft reset, else loads next value.
// Assumes the next value is already bounded by TOTAL.
module pbuf_free_ctr #(
    parameter int TOTAL  = 256,
    parameter int FREE_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic [FREE_W-1:0] free_d,
    output logic [FREE_W-1:0] free_q
);
    // Track free pages across cycles.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) free_q <= FREE_W'(TOTAL);
        else free_q <= free_d;
    end
endmodule

// File: rtl/pbuf_admit.sv
// Top: reservation-aware page admission for a shared packet buffer.
// Assumes one request and one release per direction per cycle.
module pbuf_admit
    import pbuf_admit_pkg::*;
#(
    parameter logic [2:0] ID_CODE = 3'b010,
    parameter int REQ_W  = 8,
    parameter int TOTAL  = 256,
    parameter int FREE_W = $clog2(TOTAL + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [1:0]        cfg_wr_be,
    input  logic [15:0]       cfg_wr_data,
    output logic [15:0]       cfg_rd_data,
    output logic [4:0]        page_mult,
    input  logic              soft_rst,
    input  logic              tx_req,
    input  logic [REQ_W-1:0]  tx_pages,
    output logic              tx_grant,
    input  logic              rx_req,
    input  logic [REQ_W-1:0]  rx_pages,
    output logic              rx_grant,
    input  logic              tx_rel,
    input  logic [REQ_W-1:0]  tx_rel_pages,
    input  logic              rx_rel,
    input  logic [REQ_W-1:0]  rx_rel_pages,
    output logic [FREE_W-1:0] free_pages
);
    logic [RESV_W-1:0] resv;
    logic [FREE_W-1:0] free_d;

    pbuf_cfg_regs #(.ID_CODE(ID_CODE)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wr_be(cfg_wr_be),
        .wr_data(cfg_wr_data), .rd_data(cfg_rd_data), .resv(resv), .mult(page_mult)
    );

    pbuf_admit_logic #(.REQ_W(REQ_W), .TOTAL(TOTAL), .FREE_W(FREE_W)) u_logic (
        .free_q(free_pages), .resv(resv), .soft_rst(soft_rst),
        .tx_req(tx_req), .tx_pages(tx_pages), .rx_req(rx_req), .rx_pages(rx_pages),
        .tx_rel(tx_rel), .tx_rel_pages(tx_rel_pages),
        .rx_rel(rx_rel), .rx_rel_pages(rx_rel_pages),
        .tx_grant(tx_grant), .rx_grant(rx_grant), .free_d(free_d)
    );

    pbuf_free_ctr #(.TOTAL(TOTAL), .FREE_W(FREE_W)) u_free (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .free_d(free_d), .free_q(free_pages)
    );
endmodule

// File: rtl/pbuf_admit_chk.sv
// Checker: port-level properties of the admission controller, bound to the top.
module pbuf_admit_chk #(
    parameter int REQ_W  = 8,
    parameter int TOTAL  = 256,
    parameter int FREE_W = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_wr_en,
    input logic [15:0]       cfg_rd_data,
    input logic              soft_rst,
    input logic              tx_req,
    input logic [REQ_W-1:0]  tx_pages,
    input logic              tx_grant,
    input logic              rx_req,
    input logic              rx_grant,
    input logic              tx_rel,
    input logic              rx_rel,
    input logic [FREE_W-1:0] free_pages
);
    assert_free_bounded_R8: assert property (@(posedge clk) disable iff (!rst_n)
        free_pages <= FREE_W'(TOTAL));

    assert_soft_refill_R10: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> free_pages == FREE_W'(TOTAL));

    assert_soft_no_grant_R10: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |-> !tx_grant && !rx_grant);

    assert_soft_keeps_resv_R10: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst && !cfg_wr_en |=> cfg_rd_data[7:0] == $past(cfg_rd_data[7:0]));

    assert_cfg_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr_en |=> $stable(cfg_rd_data));

    assert_tx_fits_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_grant && !tx_rel && !rx_rel |-> FREE_W'(tx_pages) <= free_pages);

    assert_tx_decrement_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_grant && !rx_grant && !tx_rel && !rx_rel && !soft_rst
        |=> free_pages == $past(free_pages) - FREE_W'($past(tx_pages)));

    assert_rx_reserve_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_grant && !tx_grant && !tx_rel && !rx_rel && cfg_rd_data[7:0] != 8'd0
        |-> free_pages > FREE_W'(cfg_rd_data[7:0]));

    assert_grant_needs_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_grant |-> tx_req) and (rx_grant |-> rx_req));
endmodule

bind pbuf_admit pbuf_admit_chk #(.REQ_W(REQ_W), .TOTAL(TOTAL), .FREE_W(FREE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_rd_data(cfg_rd_data),
    .soft_rst(soft_rst), .tx_req(tx_req), .tx_pages(tx_pages), .tx_grant(tx_grant),
    .rx_req(rx_req), .rx_grant(rx_grant), .tx_rel(tx_rel), .rx_rel(rx_rel),
    .free_pages(free_pages)
);

// File: tb/pbuf_admit_bench.sv
`timescale 1ns/1ps
module pbuf_admit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [1:0]  cfg_wr_be = 2'b00;
    logic [15:0] cfg_wr_data = 16'h0;
    logic [15:0] cfg_rd_data;
    logic [4:0]  page_mult;
    logic        soft_rst = 1'b0;
    logic        tx_req = 1'b0, rx_req = 1'b0, tx_rel = 1'b0, rx_rel = 1'b0;
    logic [7:0]  tx_pages = '0, rx_pages = '0, tx_rel_pages = '0, rx_rel_pages = '0;
    logic        tx_grant, rx_grant;
    logic [8:0]  free_pages;

    int checks = 0;
    int errors = 0;
    int m_free = 256;
    int m_resv = 0;

    always #2 clk = ~clk;

    pbuf_admit u_pbuf_admit (.*);

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // One cycle of traffic: drive, check grants, step the model, check state.
    task automatic step(input bit tq, input int tp, input bit rq, input int rp,
                        input bit tr, input int trp, input bit rr, input int rrp,
                        input bit sr);
        int avail, a2, nf;
        bit eg_t, eg_r;
        @(negedge clk);
        tx_req = tq; tx_pages = 8'(tp); rx_req = rq; rx_pages = 8'(rp);
        tx_rel = tr; tx_rel_pages = 8'(trp); rx_rel = rr; rx_rel_pages = 8'(rrp);
        soft_rst = sr;
        #1;
        avail = m_free + (tr ? trp : 0) + (rr ? rrp : 0);
        if (avail > 256) avail = 256;
        eg_t = tq && (tp <= avail);
        a2 = avail - (eg_t ? tp : 0);
        eg_r = rq && (rp <= a2) && (m_resv == 0 || a2 > m_resv);
        nf = a2 - (eg_r ? rp : 0);
        if (sr) begin eg_t = 0; eg_r = 0; nf = 256; end
        check(sr ? "R10 tx grant" : (m_resv != 0 ? "R7 tx grant" : "R4 tx grant"),
              int'(tx_grant), int'(eg_t));
        check(sr ? "R10 rx grant" : (m_resv != 0 ? "R6 rx grant" : "R5 rx grant"),
              int'(rx_grant), int'(eg_r));
        @(posedge clk);
        m_free = nf;
        #1;
        check(sr ? "R10 free" : "R8 free", int'(free_pages), m_free);
        check("R10 resv kept", int'(cfg_rd_data[7:0]), m_resv);
    endtask

    task automatic cfg_write(input logic [1:0] be, input logic [15:0] d);
        @(negedge clk);
        tx_req = 0; rx_req = 0; tx_rel = 0; rx_rel = 0; soft_rst = 0;
        cfg_wr_en = 1; cfg_wr_be = be; cfg_wr_data = d;
        @(posedge clk);
        if (be[0]) m_resv = int'(d[7:0]);
        #1;
        cfg_wr_en = 0;
        check("R3 cfg word", int'(cfg_rd_data), 16'h0400 | m_resv);
        check("R3 free stable", int'(free_pages), m_free);
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        check("R1 free after reset", int'(free_pages), 256);
        check("R1 tx grant idle", int'(tx_grant), 0);
        check("R1 rx grant idle", int'(rx_grant), 0);
        check("R2 cfg word reset", int'(cfg_rd_data), 16'h0400);
        check("R11 page mult", int'(page_mult), 2);

        cfg_write(2'b11, 16'hFF37);
        check("R3 high byte ignored", int'(cfg_rd_data), 16'h0437);
        cfg_write(2'b10, 16'hAA12);
        check("R3 low lane off", int'(cfg_rd_data), 16'h0437);

        // Reservation 10: fill to exactly the reservation.
        cfg_write(2'b01, 16'h000A);
        step(1, 246, 0, 0, 0, 0, 0, 0, 0);
        check("R4 free after tx", int'(free_pages), 10);
        step(0, 0, 1, 1, 0, 0, 0, 0, 0);
        check("R6 equal denied", int'(rx_grant), 0);
        step(1, 5, 0, 0, 0, 0, 0, 0, 0);
        check("R7 tx past reserve", int'(free_pages), 5);
        step(0, 0, 0, 0, 1, 200, 1, 200, 0);
        check("R8 saturation", int'(free_pages), 256);

        // Release applied before allocation in the same cycle.
        cfg_write(2'b01, 16'h0000);
        step(1, 255, 0, 0, 0, 0, 0, 0, 0);
        step(1, 3, 0, 0, 0, 0, 1, 2, 0);
        check("R8 release first", int'(free_pages), 0);

        // Transmit judged before receive.
        step(0, 0, 0, 0, 0, 0, 0, 0, 1);
        step(1, 200, 1, 100, 0, 0, 0, 0, 0);
        check("R9 rx after tx", int'(free_pages), 56);
        step(0, 0, 1, 56, 0, 0, 0, 0, 0);
        check("R5 exact fit", int'(free_pages), 0);

        // Soft reset keeps the reservation.
        cfg_write(2'b01, 16'h0021);
        step(1, 10, 1, 10, 0, 0, 0, 0, 1);
        check("R10 resv after soft", int'(cfg_rd_data[7:0]), 8'h21);
        check("R10 free after soft", int'(free_pages), 256);

        // Random traffic against the model.
        for (int i = 0; i < 3000; i++) begin
            if (i % 400 == 0) cfg_write(2'b01, 16'($urandom_range(0, 40)));
            step(bit'($urandom_range(0, 1)), $urandom_range(0, 60),
                 bit'($urandom_range(0, 1)), $urandom_range(0, 60),
                 bit'($urandom_range(0, 1)), $urandom_range(0, 50),
                 bit'($urandom_range(0, 1)), $urandom_range(0, 50),
                 ($urandom_range(0, 199) == 0));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule